// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital side of a successive approximation converter. When it is idle and sees a start request, it opens a sample window for the external sample-and-hold and then runs a binary search over the output code. Each trial sets one bit, beginning with the most significant, on top of the bits already kept. The trial code goes to an external DAC, and a single comparator bit returns to say whether the held input is above that level. The controller keeps or drops the bit on that answer and moves one position down.

The schedule is fixed in clock cycles. There is a sample window, a long first trial, shorter trials for the remaining bits and a short closing phase. Every conversion therefore takes the same number of clocks, which is 32 for the default 8-bit width. At the end a one-clock done pulse appears while the result output already carries the finished code. The result is held until the next conversion completes. The DAC, the comparator and the sample-and-hold are outside this block and are reached only through its ports.

The states are IDLE, SAMPLE, FIRST_BIT, NEXT_BITS and FINISH:
- IDLE goes to SAMPLE on an accepted start.
- SAMPLE goes to FIRST_BIT when its window expires.
- FIRST_BIT and NEXT_BITS go to NEXT_BITS after a decision while lower bits remain, and to FINISH after the LSB decision.
- FINISH goes back to IDLE when its window expires.
- A synchronous reset forces IDLE from any state.

Top module: `sar_engine`

## Requirements
- R1: Bits are tried from the MSB down to the LSB. The first trial code driven on `dac_code` has only bit WIDTH-1 set. Each later trial code is the set of kept bits plus the new trial bit set to 1.
- R2: A trial bit stays 1 when `cmp_above` is 1 at its decision clock, and is cleared otherwise. With a comparator that returns 1 whenever the analog level is at or above the trial code, `result` equals the analog level.
- R3: `sample_hold` is 1 for exactly the first 12 clocks after an accepted start and is 0 at every other time.
- R4: The MSB trial occupies 4 clocks and each later trial occupies 2 clocks. For WIDTH 8, clock 17 after the start is the first clock that shows the second trial code.
- R5: `done` is 1 for exactly one clock. For WIDTH 8 it is clock 32 after the edge that accepted the start, after the 2-clock closing phase.
- R6: `result` holds the finished code in the `done` clock and keeps it until the next conversion finishes.
- R7: A start request is accepted only in IDLE. A start during a conversion changes neither its timing nor its result.
- R8: `cmp_above` is used only on the last clock of each bit trial. Its value on any other clock of the trial has no effect on the result.
- R9: A synchronous reset returns the block to IDLE with `result`, `dac_code`, `done` and `sample_hold` all 0.
- R10: WIDTH is a parameter. A 10-bit instance converts correctly in 12 + 4 + 2*9 + 2 = 36 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, honoured only when idle |
| cmp_above | input | 1 | Comparator: 1 when the held input is above the trial level |
| dac_code | output | WIDTH | Trial code for the external DAC |
| sample_hold | output | 1 | High during the sample window |
| result | output | WIDTH | Last finished conversion code |
| done | output | 1 | One-clock completion pulse |

## Verification
The checker watches several properties on every clock, relative to the rising edge of `sample_hold`:
- the length of the sample window;
- the exact clock in which `done` comes, and that it lasts a single clock;
- the single clock in which `result` may change;
- the MSB-only first trial code;
- the cleared outputs after reset.

Only the bench scenarios can show the numeric correctness of the binary search across many input levels, and that stray starts and stray comparator values in non-decision clocks do nothing. The same holds for the recovery after a reset in the middle of a conversion and for the longer schedule of the 10-bit instance.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_SAMPLE    = 3'd1,
        S_FIRST_BIT = 3'd2,
        S_NEXT_BITS = 3'd3,
        S_FINISH    = 3'd4
    } conv_state_e;

endpackage

// File: rtl/sar_phase_timer.sv
// Down-counter that measures the length of the current phase.
module sar_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/sar_sequencer.sv
// Phase state machine: sample, first trial, later trials, finish.
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int SAMPLE_CYC = 12,
    parameter int FIRST_CYC  = 4,
    parameter int BIT_CYC    = 2,
    parameter int END_CYC    = 2,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             phase_done,
    input  logic             lsb_trial,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             conv_clear,
    output logic             trial_init,
    output logic             decide,
    output logic             sample_hold,
    output logic             done
);

    localparam logic [CNT_W-1:0] SAMPLE_LOAD = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0] FIRST_LOAD  = CNT_W'(FIRST_CYC - 1);
    localparam logic [CNT_W-1:0] BIT_LOAD    = CNT_W'(BIT_CYC - 1);
    localparam logic [CNT_W-1:0] END_LOAD    = CNT_W'(END_CYC - 1);

    conv_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions and phase timer reloads
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d    = S_SAMPLE;
                    timer_load = 1'b1;
                    timer_val  = SAMPLE_LOAD;
                end
            end
            S_SAMPLE: begin
                if (phase_done) begin
                    state_d    = S_FIRST_BIT;
                    timer_load = 1'b1;
                    timer_val  = FIRST_LOAD;
                end
            end
            S_FIRST_BIT, S_NEXT_BITS: begin
                if (phase_done) begin
                    timer_load = 1'b1;
                    if (lsb_trial) begin
                        state_d   = S_FINISH;
                        timer_val = END_LOAD;
                    end else begin
                        state_d   = S_NEXT_BITS;
                        timer_val = BIT_LOAD;
                    end
                end
            end
            S_FINISH: begin
                if (phase_done) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        conv_clear  = 1'b0;
        trial_init  = 1'b0;
        decide      = 1'b0;
        sample_hold = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            S_IDLE:      conv_clear = start;
            S_SAMPLE: begin
                sample_hold = 1'b1;
                trial_init  = phase_done;
            end
            S_FIRST_BIT: decide = phase_done;
            S_NEXT_BITS: decide = phase_done;
            S_FINISH:    done   = phase_done;
            default: ;
        endcase
    end

endmodule

// File: rtl/sar_trial_register.sv
// Holds the kept bits, the one-hot trial pointer and the finished result.
module sar_trial_register #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             init,
    input  logic             decide,
    input  logic             cmp_above,
    output logic [WIDTH-1:0] code,
    output logic             lsb_trial,
    output logic [WIDTH-1:0] result
);

    localparam logic [WIDTH-1:0] MSB_ONE = WIDTH'(1) << (WIDTH - 1);

    logic [WIDTH-1:0] code_q, mask_q, result_q;
    logic [WIDTH-1:0] kept, mask_next, code_next;

    always_comb begin
        kept      = cmp_above ? code_q : (code_q & ~mask_q);
        mask_next = mask_q >> 1;
        code_next = kept | mask_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= '0;
            mask_q   <= '0;
            result_q <= '0;
        end else if (clear) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (init) begin
            code_q <= MSB_ONE;
            mask_q <= MSB_ONE;
        end else if (decide) begin
            code_q <= code_next;
            mask_q <= mask_next;
            if (mask_q[0]) begin
                result_q <= code_next;
            end
        end
    end

    assign code      = code_q;
    assign lsb_trial = mask_q[0];
    assign result    = result_q;

endmodule

// File: rtl/sar_engine.sv
// Successive approximation conversion controller, top level.
module sar_engine #(
    parameter int WIDTH      = 8,
    parameter int SAMPLE_CYC = 12,
    parameter int FIRST_CYC  = 4,
    parameter int BIT_CYC    = 2,
    parameter int END_CYC    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_above,
    output logic [WIDTH-1:0] dac_code,
    output logic             sample_hold,
    output logic [WIDTH-1:0] result,
    output logic             done
);

    localparam int MAX_A   = (SAMPLE_CYC > FIRST_CYC) ? SAMPLE_CYC : FIRST_CYC;
    localparam int MAX_B   = (BIT_CYC > END_CYC) ? BIT_CYC : END_CYC;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic             timer_load, phase_done, lsb_trial;
    logic [CNT_W-1:0] timer_val;
    logic             conv_clear, trial_init, decide;

    sar_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (phase_done)
    );

    sar_sequencer #(
        .SAMPLE_CYC (SAMPLE_CYC),
        .FIRST_CYC  (FIRST_CYC),
        .BIT_CYC    (BIT_CYC),
        .END_CYC    (END_CYC),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .phase_done  (phase_done),
        .lsb_trial   (lsb_trial),
        .timer_load  (timer_load),
        .timer_val   (timer_val),
        .conv_clear  (conv_clear),
        .trial_init  (trial_init),
        .decide      (decide),
        .sample_hold (sample_hold),
        .done        (done)
    );

    sar_trial_register #(.WIDTH(WIDTH)) u_trial (
        .clk       (clk),
        .rst       (rst),
        .clear     (conv_clear),
        .init      (trial_init),
        .decide    (decide),
        .cmp_above (cmp_above),
        .code      (dac_code),
        .lsb_trial (lsb_trial),
        .result    (result)
    );

endmodule

// File: rtl/sar_engine_checker.sv
// Cycle checks tied to the rising edge of the sample window.
module sar_engine_checker #(
    parameter int WIDTH      = 8,
    parameter int SAMPLE_CYC = 12,
    parameter int FIRST_CYC  = 4,
    parameter int BIT_CYC    = 2,
    parameter int END_CYC    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] dac_code,
    input logic             sample_hold,
    input logic [WIDTH-1:0] result,
    input logic             done
);

    localparam int TOTAL = SAMPLE_CYC + FIRST_CYC + BIT_CYC * (WIDTH - 1) + END_CYC;
    localparam logic [WIDTH-1:0] MSB_ONE = WIDTH'(1) << (WIDTH - 1);

    // cyc_q equals k in clock k of a conversion (k >= 2), 0 after reset
    logic       sh_q;
    logic [7:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= 1'b0;
            cyc_q <= '0;
        end else begin
            sh_q <= sample_hold;
            if (sample_hold && !sh_q) begin
                cyc_q <= 8'd2;
            end else if (cyc_q != 8'd0 && cyc_q != 8'hFF) begin
                cyc_q <= cyc_q + 8'd1;
            end
        end
    end

    a_r3_window_high: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 8'd2 && cyc_q <= 8'(SAMPLE_CYC)) |-> sample_hold);

    a_r3_window_low: assert property (@(posedge clk) disable iff (rst)
        (cyc_q > 8'(SAMPLE_CYC) && cyc_q <= 8'(TOTAL)) |-> !sample_hold);

    a_r5_done_clock: assert property (@(posedge clk) disable iff (rst)
        done |-> (cyc_q == 8'(TOTAL)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r1_msb_first: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == 8'(SAMPLE_CYC + 1)) |-> (dac_code == MSB_ONE));

    a_r6_result_update: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && result != $past(result)) |-> (cyc_q == 8'(TOTAL - END_CYC + 1)));

    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (result == '0 && dac_code == '0 && !done && !sample_hold));

endmodule

bind sar_engine sar_engine_checker #(
    .WIDTH      (WIDTH),
    .SAMPLE_CYC (SAMPLE_CYC),
    .FIRST_CYC  (FIRST_CYC),
    .BIT_CYC    (BIT_CYC),
    .END_CYC    (END_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dac_code    (dac_code),
    .sample_hold (sample_hold),
    .result      (result),
    .done        (done)
);

// File: tb/sar_engine_bench.sv
module sar_engine_bench;

    localparam int NVEC = 8;
    // each entry: {analog level, expected result}
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        16'h0000, 16'hFFFF, 16'h8080, 16'h7F7F,
        16'h5555, 16'hAAAA, 16'h0101, 16'hFEFE
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // 8-bit instance
    logic       start8 = 1'b0;
    logic       cmp8, sh8, done8;
    logic [7:0] dac8, res8;
    logic [7:0] level8 = 8'd0;
    bit         glitch8 = 1'b0;
    int         bk = 0;

    // 10-bit instance
    logic       start10 = 1'b0;
    logic       cmp10, sh10, done10;
    logic [9:0] dac10, res10;
    logic [9:0] level10 = 10'd0;

    int n_cmp = 0;
    int n_bad = 0;

    // comparator is wrong in non-decision clocks of bit trials when glitching
    function automatic bit off_decision(input int k);
        return (k >= 13 && k <= 15) || (k >= 17 && k <= 29 && (k % 2) == 1);
    endfunction

    assign cmp8  = (level8 >= dac8) ^ (glitch8 && off_decision(bk));
    assign cmp10 = (level10 >= dac10);

    sar_engine u_sar_engine (
        .clk(clk), .rst(rst), .start(start8), .cmp_above(cmp8),
        .dac_code(dac8), .sample_hold(sh8), .result(res8), .done(done8)
    );

    sar_engine #(.WIDTH(10)) u_sar_engine_w10 (
        .clk(clk), .rst(rst), .start(start10), .cmp_above(cmp10),
        .dac_code(dac10), .sample_hold(sh10), .result(res10), .done(done10)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run8(input logic [7:0] vin, input logic [7:0] exp_res, input bit gl, input bit spam);
        int done_at = 0, done_cnt = 0, sh_early = 0, sh_all = 0;
        logic [7:0] d13 = 0, d16 = 0, d17 = 0, res_done = 0;
        @(negedge clk);
        level8 = vin; glitch8 = gl; start8 = 1'b1; bk = 0;
        @(negedge clk);
        for (int k = 1; k <= 40; k++) begin
            if (k > 1) @(negedge clk);
            bk = k;
            start8 = spam && (k == 5 || k == 20);
            if (sh8) begin
                sh_all++;
                if (k <= 12) sh_early++;
            end
            if (done8) begin
                done_cnt++;
                done_at = k;
                res_done = res8;
            end
            if (k == 13) d13 = dac8;
            if (k == 16) d16 = dac8;
            if (k == 17) d17 = dac8;
        end
        start8 = 1'b0; glitch8 = 1'b0; bk = 0;
        check(res8 == exp_res, gl ? "R8 glitch result" : "R2 result", res8, exp_res);
        check(res_done == exp_res, "R6 result at done", res_done, exp_res);
        check(done_at == 32, spam ? "R7 done clock with stray starts" : "R5 done clock", done_at, 32);
        check(done_cnt == 1, "R5 done width", done_cnt, 1);
        check(sh_early == 12 && sh_all == 12, spam ? "R7 sample window" : "R3 sample window", sh_all, 12);
        check(d13 == 8'h80 && d16 == 8'h80, "R1 first trial code", d16, 8'h80);
        check(d17 == ((vin & 8'h80) | 8'h40), "R4 second trial at clock 17", d17, (vin & 8'h80) | 8'h40);
    endtask

    task automatic run10(input logic [9:0] vin);
        int done_at = 0;
        @(negedge clk);
        level10 = vin; start10 = 1'b1;
        @(negedge clk);
        start10 = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            if (k > 1) @(negedge clk);
            if (done10) done_at = k;
        end
        check(res10 == vin, "R10 10-bit result", res10, vin);
        check(done_at == 36, "R10 10-bit done clock", done_at, 36);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(res8 == 0 && dac8 == 0, "R9 reset result/code", res8, 0);
        check(!done8 && !sh8, "R9 reset strobes", {done8, sh8}, 0);

        // vector table walk (R1 R2 R3 R4 R5 R6)
        for (int i = 0; i < NVEC; i++) begin
            run8(VEC[i][15:8], VEC[i][7:0], 1'b0, 1'b0);
        end

        // R7 stray starts during a conversion
        run8(8'h3C, 8'h3C, 1'b0, 1'b1);

        // R8 comparator wrong on every non-decision clock
        run8(8'hA5, 8'hA5, 1'b1, 1'b0);
        run8(8'h5A, 8'h5A, 1'b1, 1'b0);

        // R6 result held while idle
        repeat (20) @(negedge clk);
        check(res8 == 8'h5A, "R6 result hold", res8, 8'h5A);

        // R9 reset in mid conversion
        begin
            int bad_done = 0, bad_sh = 0, bad_res = 0;
            @(negedge clk);
            level8 = 8'hC3; start8 = 1'b1;
            @(negedge clk);
            start8 = 1'b0;
            repeat (19) @(negedge clk);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            for (int k = 0; k < 40; k++) begin
                if (done8) bad_done++;
                if (sh8) bad_sh++;
                if (res8 != 0 || dac8 != 0) bad_res++;
                @(negedge clk);
            end
            check(bad_done == 0 && bad_sh == 0, "R9 idle after reset", bad_done + bad_sh, 0);
            check(bad_res == 0, "R9 result cleared", bad_res, 0);
        end
        run8(8'hC3, 8'hC3, 1'b0, 1'b0);

        // R10 wider instance
        run10(10'h3FF);
        run10(10'h000);
        run10(10'h2A7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule